// File: doc/BRIEF.md
# Unary and Register-Move Integer Unit

This unit executes the integer operations of a 32-bit register machine that read at most one source value or that only move values between registers. It handles sign operations (negate, absolute value, negated absolute value), register transfers (copy, move with clear, exchange) and constant or program-counter reads (zero, all ones, a capability word, the current PC). A decoder upstream supplies a function group bit, a function code, the two register indices with their current contents, and the PC. The unit answers with up to two register write requests and an illegal-operation flag.

Each request is presented with `issue` high for one clock. The results appear on registered outputs on the next rising edge and stay there for exactly one cycle. The exchange and the move-with-clear operations are the only ones that use the second write port. When both operands name the same register, only the first port writes.

Top module: `unary_exec`

## Requirements
- R1: After reset, and in any cycle not following an accepted `issue`, `wa_en`, `wb_en` and `illegal` are low.
- R2: Two-operand code 0x0000 (`fn_unary`=0, `fn_code`=0x00000) writes the two's-complement negation of `rb` to register `idx_a`. The negation of 0x80000000 is 0x80000000.
- R3: Two-operand code 0x0001 writes the absolute value of `rb` to `idx_a`, and 0x80000000 gives 0x80000000. Code 0x0002 writes the negated absolute value, so a negative `rb` passes through unchanged.
- R4: Two-operand code 0x0003 writes the old `rb` to `idx_a` on port A and the old `ra` to `idx_b` on port B, in the same cycle.
- R5: Two-operand code 0x0004 writes `rb` to `idx_a` and leaves port B idle. Code 0x0005 writes `rb` to `idx_a` and zero to `idx_b`.
- R6: One-operand code 0x00000 (`fn_unary`=1) writes `pc` to `idx_a`.
- R7: One-operand code 0x00001 writes the constant 0x00000007 to `idx_a`. Code 0x00002 writes 0x00000000 and code 0x00003 writes 0xFFFFFFFF.
- R8: If code 0x0003 or 0x0005 is issued with `idx_a` equal to `idx_b`, port A performs its write and port B stays disabled.
- R9: Any other code raises `illegal` with both write enables low. For two-operand codes this includes any code with `fn_code[19:16]` nonzero.
- R10: Every result appears on the first rising edge after the `issue` cycle and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Request valid this cycle |
| fn_unary | input | 1 | 1 selects the one-operand group, 0 the two-operand group |
| fn_code | input | 20 | Function code within the group |
| idx_a | input | 4 | Index of register a |
| idx_b | input | 4 | Index of register b |
| ra | input | 32 | Contents of register a |
| rb | input | 32 | Contents of register b |
| pc | input | 32 | Current program counter |
| wa_en | output | 1 | Write enable, port A |
| wa_idx | output | 4 | Destination index, port A |
| wa_data | output | 32 | Write data, port A |
| wb_en | output | 1 | Write enable, port B |
| wb_idx | output | 4 | Destination index, port B |
| wb_data | output | 32 | Write data, port B |
| illegal | output | 1 | Unsupported code was issued |

## Verification
The unit holds no state apart from the one-cycle result register, so any internal fault shows at the ports in the cycle that follows the faulty request. A wrong decode appears as a missing or extra enable, or as a raised `illegal`. A wrong data path appears as a wrong word at an otherwise correct destination. A stale result register would leave an enable high for a second cycle. The two-port operations and the equal-index case are the ones most likely to expose a crossed port or a missing suppression.

// File: rtl/unary_exec.sv
module unary_exec #(
  parameter int XLEN     = 32,
  parameter int RIDX     = 4,
  parameter int CODE_W   = 20,
  parameter int CAP_WORD = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic            fn_unary,
  input  logic [CODE_W-1:0] fn_code,
  input  logic [RIDX-1:0] idx_a,
  input  logic [RIDX-1:0] idx_b,
  input  logic [XLEN-1:0] ra,
  input  logic [XLEN-1:0] rb,
  input  logic [XLEN-1:0] pc,
  output logic            wa_en,
  output logic [RIDX-1:0] wa_idx,
  output logic [XLEN-1:0] wa_data,
  output logic            wb_en,
  output logic [RIDX-1:0] wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            illegal
);
  localparam int BIN_W = 16;

  logic [XLEN-1:0] neg_b;
  logic            b_neg;
  logic            hi_clear;
  logic            same_reg;

  assign neg_b    = '0 - rb;
  assign b_neg    = rb[XLEN-1];
  assign hi_clear = (fn_code[CODE_W-1:BIN_W] == '0);
  assign same_reg = (idx_a == idx_b);

  logic            n_aen, n_ben, n_ill;
  logic [XLEN-1:0] n_adat, n_bdat;

  always_comb begin
    n_aen  = 1'b1;
    n_ben  = 1'b0;
    n_ill  = 1'b0;
    n_adat = '0;
    n_bdat = '0;
    if (fn_unary) begin
      case (fn_code)
        CODE_W'(0): n_adat = pc;
        CODE_W'(1): n_adat = XLEN'(CAP_WORD);
        CODE_W'(2): n_adat = '0;
        CODE_W'(3): n_adat = '1;
        default: begin n_aen = 1'b0; n_ill = 1'b1; end
      endcase
    end else if (!hi_clear) begin
      n_aen = 1'b0;
      n_ill = 1'b1;
    end else begin
      case (fn_code[BIN_W-1:0])
        16'h0000: n_adat = neg_b;
        16'h0001: n_adat = b_neg ? neg_b : rb;
        16'h0002: n_adat = b_neg ? rb : neg_b;
        16'h0003: begin n_adat = rb; n_bdat = ra; n_ben = !same_reg; end
        16'h0004: n_adat = rb;
        16'h0005: begin n_adat = rb; n_bdat = '0; n_ben = !same_reg; end
        default: begin n_aen = 1'b0; n_ill = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_en   <= 1'b0;
      wb_en   <= 1'b0;
      illegal <= 1'b0;
      wa_idx  <= '0;
      wb_idx  <= '0;
      wa_data <= '0;
      wb_data <= '0;
    end else begin
      wa_en   <= issue & n_aen;
      wb_en   <= issue & n_ben;
      illegal <= issue & n_ill;
      if (issue) begin
        wa_idx  <= idx_a;
        wb_idx  <= idx_b;
        wa_data <= n_adat;
        wb_data <= n_bdat;
      end
    end
  end
endmodule

module unary_exec_chk #(
  parameter int XLEN   = 32,
  parameter int RIDX   = 4,
  parameter int CODE_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue,
  input logic              fn_unary,
  input logic [CODE_W-1:0] fn_code,
  input logic [RIDX-1:0]   idx_a,
  input logic [RIDX-1:0]   idx_b,
  input logic [XLEN-1:0]   ra,
  input logic [XLEN-1:0]   rb,
  input logic [XLEN-1:0]   pc,
  input logic              wa_en,
  input logic [RIDX-1:0]   wa_idx,
  input logic [XLEN-1:0]   wa_data,
  input logic              wb_en,
  input logic [RIDX-1:0]   wb_idx,
  input logic [XLEN-1:0]   wb_data,
  input logic              illegal
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(issue) && $past(rst_n)) |-> (!wa_en && !wb_en && !illegal));

  // R9
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wa_en && !wb_en));

  // R8
  port_b_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wa_en && wa_idx != wb_idx));

  // R4
  swap_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(issue) && !$past(fn_unary) && $past(fn_code) == 20'h00003
     && $past(idx_a) != $past(idx_b))
    |-> (wa_en && wb_en && wa_data == $past(rb) && wb_data == $past(ra)));

  // R5
  move_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(issue) && !$past(fn_unary) && $past(fn_code) == 20'h00005
     && $past(idx_a) != $past(idx_b))
    |-> (wa_en && wb_en && wb_data == '0 && wa_data == $past(rb)));

  // R6
  read_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(issue) && $past(fn_unary) && $past(fn_code) == 20'h00000)
    |-> (wa_en && !wb_en && wa_data == $past(pc) && wa_idx == $past(idx_a)));
endmodule

bind unary_exec unary_exec_chk #(.XLEN(XLEN), .RIDX(RIDX), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .fn_unary(fn_unary), .fn_code(fn_code),
  .idx_a(idx_a), .idx_b(idx_b), .ra(ra), .rb(rb), .pc(pc),
  .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
  .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal));

// File: tb/test_unary_exec.sv
module test_unary_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic        fn_unary = 1'b0;
  logic [19:0] fn_code = '0;
  logic [3:0]  idx_a = 4'd3, idx_b = 4'd5;
  logic [31:0] ra = '0, rb = '0, pc = '0;
  logic        wa_en, wb_en, illegal;
  logic [3:0]  wa_idx, wb_idx;
  logic [31:0] wa_data, wb_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  unary_exec i_unary_exec (
    .clk(clk), .rst_n(rst_n), .issue(issue), .fn_unary(fn_unary), .fn_code(fn_code),
    .idx_a(idx_a), .idx_b(idx_b), .ra(ra), .rb(rb), .pc(pc),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal));

  localparam int NV = 18;
  localparam logic        V_UN  [NV] = '{0,0,0,0,0,0,0,0,0,0,1,1,1,1,0,1,1,0};
  localparam logic [19:0] V_FN  [NV] = '{20'h0, 20'h0, 20'h1, 20'h1, 20'h1, 20'h2, 20'h2,
    20'h3, 20'h4, 20'h5, 20'h0, 20'h1, 20'h2, 20'h3, 20'h6, 20'h4, 20'h01000, 20'h10000};
  localparam logic [31:0] V_RA  [NV] = '{32'h11111111, 32'h11111111, 32'h11111111,
    32'h11111111, 32'h11111111, 32'h11111111, 32'h11111111, 32'hAAAA0001, 32'h11111111,
    32'h11111111, 32'h11111111, 32'h11111111, 32'h11111111, 32'h11111111, 32'h11111111,
    32'h11111111, 32'h11111111, 32'h11111111};
  localparam logic [31:0] V_RB  [NV] = '{32'h5, 32'h80000000, 32'hFFFFFFF6, 32'h80000000,
    32'h7, 32'h9, 32'hFFFFFFF0, 32'h5555000F, 32'hDEADBEEF, 32'h12345678, 32'h22,
    32'h22, 32'h22, 32'h22, 32'h22, 32'h22, 32'h22, 32'h22};
  localparam logic        V_AEN [NV] = '{1,1,1,1,1,1,1,1,1,1,1,1,1,1,0,0,0,0};
  localparam logic [31:0] V_AD  [NV] = '{32'hFFFFFFFB, 32'h80000000, 32'hA, 32'h80000000,
    32'h7, 32'hFFFFFFF7, 32'hFFFFFFF0, 32'h5555000F, 32'hDEADBEEF, 32'h12345678,
    32'h00400010, 32'h7, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic        V_BEN [NV] = '{0,0,0,0,0,0,0,1,0,1,0,0,0,0,0,0,0,0};
  localparam logic [31:0] V_BD  [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'hAAAA0001, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam string V_REQ [NV] = '{"R2","R2","R3","R3","R3","R3","R3","R4","R5","R5",
    "R6","R7","R7","R7","R9","R9","R9","R9"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic un, input logic [19:0] fn, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] p);
    @(negedge clk);
    issue = 1'b1; fn_unary = un; fn_code = fn; ra = a; rb = b; pc = p;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic check_result(input string req, input logic aen, input logic [31:0] ad,
                              input logic ben, input logic [31:0] bd, input logic ill);
    check(req, {31'd0, wa_en}, {31'd0, aen});
    check(req, {31'd0, wb_en}, {31'd0, ben});
    check(req, {31'd0, illegal}, {31'd0, ill});
    if (aen) begin
      check(req, wa_data, ad);
      check(req, {28'd0, wa_idx}, {28'd0, idx_a});
    end
    if (ben) begin
      check(req, wb_data, bd);
      check(req, {28'd0, wb_idx}, {28'd0, idx_b});
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {29'd0, wa_en, wb_en, illegal}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {29'd0, wa_en, wb_en, illegal}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_op(V_UN[i], V_FN[i], V_RA[i], V_RB[i], 32'h00400010);
      check_result(V_REQ[i], V_AEN[i], V_AD[i], V_BEN[i], V_BD[i], !V_AEN[i]);
      // R10 result lasts one cycle only
      @(negedge clk);
      check("R10", {29'd0, wa_en, wb_en, illegal}, 32'd0);
    end

    // R10 inputs changing without issue produce nothing
    @(negedge clk);
    fn_unary = 1'b0; fn_code = 20'h3; ra = 32'h1; rb = 32'h2;
    @(negedge clk);
    check("R10", {29'd0, wa_en, wb_en, illegal}, 32'd0);

    // R8 same register for swap and move
    idx_a = 4'd7; idx_b = 4'd7;
    run_op(1'b0, 20'h3, 32'hCAFE0000, 32'h0000BEEF, 32'h0);
    check_result("R8", 1'b1, 32'h0000BEEF, 1'b0, 32'h0, 1'b0);
    run_op(1'b0, 20'h5, 32'hCAFE0000, 32'h0BADF00D, 32'h0);
    check_result("R8", 1'b1, 32'h0BADF00D, 1'b0, 32'h0, 1'b0);

    // R4 swap with other indices, R2 negate zero, R3 nabs zero
    idx_a = 4'd0; idx_b = 4'd15;
    run_op(1'b0, 20'h3, 32'h00000001, 32'hFFFFFFFF, 32'h0);
    check_result("R4", 1'b1, 32'hFFFFFFFF, 1'b1, 32'h00000001, 1'b0);
    run_op(1'b0, 20'h0, 32'h0, 32'h0, 32'h0);
    check_result("R2", 1'b1, 32'h0, 1'b0, 32'h0, 1'b0);
    run_op(1'b0, 20'h2, 32'h0, 32'h0, 32'h0);
    check_result("R3", 1'b1, 32'h0, 1'b0, 32'h0, 1'b0);
    run_op(1'b1, 20'h0, 32'h0, 32'h0, 32'hFFFFFFFC);
    check_result("R6", 1'b1, 32'hFFFFFFFC, 1'b0, 32'h0, 1'b0);

    // R1 reset in mid-result clears outputs
    run_op(1'b1, 20'h3, 32'h0, 32'h0, 32'h0);
    #1 rst_n = 1'b0;
    #1 check("R1", {29'd0, wa_en, wb_en, illegal}, 32'd0);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule